// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reset

This block turns two quadrature phase signals and an index pulse into a 32-bit position count. It counts every edge of both phases, so one full encoder cycle moves the count by four. The phase inputs and the index are expected to be synchronised and free of glitches before they reach the block. The count wraps within the range zero to a programmable ceiling. In one mode, a qualified index edge returns the count to zero. The qualifying index edge is a chosen edge direction that coincides with a chosen pair of phase levels.

Software drives the block through a small register port. Writes are accepted on every cycle, and a read returns the addressed register combinationally, so the port has no handshake and no back-pressure. Events are recorded in sticky status bits: a change of direction, a count reset or wrap while moving up, the same while moving down, and an illegal double-phase transition. An interrupt line is raised while any status bit is set and not masked.

Register addresses: 0 control, 1 ceiling, 2 count (read only), 3 status (write 1 to clear), 4 interrupt mask. Any other address reads as zero. In the control register, bit 0 is enable, bit 4 selects the index edge (1 rising, 0 falling), bit 5 swaps the phases, bit 8 selects the ceiling-only mode, and bits 10:9 select the index gating. The remaining control bits read as zero.

Top module: `qenc_counter`

## Requirements
- R1: After reset, control reads 0, ceiling reads 0xFFFFFFFF, count reads 0, status reads 0, mask reads 0x3F and irq is low.
- R2: While enabled, each cycle in which exactly one effective phase changes moves the count by one, on the edge after the change. The order AB = 00,10,11,01,00 counts up and the reverse order counts down.
- R3: A cycle in which both effective phases change leaves the count and the direction unchanged and sets status bit 4.
- R4: When control bit 5 is set, the effective phase A is the B pin and the effective phase B is the A pin, which reverses the counting direction of a given pin sequence.
- R5: An up step with count at or above the ceiling gives 0 and sets status bit 2. A down step at count 0 gives the ceiling and sets status bit 1.
- R6: With control bit 8 clear, an index edge of the selected polarity returns the count to 0, provided the effective {A,B} levels equal control bits 10:9. This index reset takes priority over a phase step in the same cycle. It sets status bit 2 if the last step direction was up, or status bit 1 if it was down. With bit 8 set, the index has no effect.
- R7: A phase step whose direction differs from the last step direction sets status bit 3. The direction after reset is up.
- R8: While control bit 0 is clear, the count holds and no status bit is set.
- R9: A control write while enabled changes only bit 0. The other bits keep their values.
- R10: Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear. irq is high exactly when some status bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| phase_a | input | 1 | Encoder phase A, synchronised |
| phase_b | input | 1 | Encoder phase B, synchronised |
| index_in | input | 1 | Encoder index, synchronised |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
Assertions check the following on every cycle:
- the count holds while the block is disabled;
- an up step below the ceiling adds exactly one;
- a down step from zero loads the ceiling;
- a qualified index clears the count;
- the locked control bits do not move while enabled;
- status bits stay set until written;
- a double-phase transition raises the error bit.

The direction decode order, the effect of the swap, the four gating and two edge-polarity choices, the ignored index in ceiling mode, and the masking of the interrupt are only shown by the bench scenarios. These scenarios are compared against a behavioural model on each clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ST_W = 6;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CEIL = 1;
  localparam int ADDR_CNT  = 2;
  localparam int ADDR_STAT = 3;
  localparam int ADDR_MASK = 4;

  localparam int CB_EN      = 0;
  localparam int CB_IDXRISE = 4;
  localparam int CB_SWAP    = 5;
  localparam int CB_CEILMD  = 8;
  localparam int CB_GATE    = 9;

  localparam int SB_RST_DN = 1;
  localparam int SB_RST_UP = 2;
  localparam int SB_DIR    = 3;
  localparam int SB_PERR   = 4;
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap,
  input  logic       idx_rise,
  input  logic [1:0] gate,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       idx_in,
  output logic       step,
  output logic       up,
  output logic       perr,
  output logic       idx_hit
);
  logic a_e, b_e, a_p, b_p, i_p, da, db, idx_edge;

  assign a_e = swap ? b_in : a_in;
  assign b_e = swap ? a_in : b_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
      i_p <= 1'b0;
    end else begin
      a_p <= a_e;
      b_p <= b_e;
      i_p <= idx_in;
    end
  end

  assign da       = a_e ^ a_p;
  assign db       = b_e ^ b_p;
  assign step     = da ^ db;
  assign perr     = da & db;
  assign up       = a_e ^ b_p;
  assign idx_edge = idx_rise ? (idx_in & ~i_p) : (~idx_in & i_p);
  assign idx_hit  = idx_edge && ({a_e, b_e} == gate);
endmodule

// File: rtl/qenc_position.sv
module qenc_position #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             idx_mode,
  input  logic             step,
  input  logic             up,
  input  logic             idx_hit,
  input  logic [CNT_W-1:0] ceil,
  output logic [CNT_W-1:0] count,
  output logic             ev_rst_up,
  output logic             ev_rst_dn,
  output logic             ev_dir
);
  logic dir_up, do_idx, do_step, at_top, at_zero;

  assign do_idx  = en && idx_mode && idx_hit;
  assign do_step = en && !do_idx && step;
  assign at_top  = (count >= ceil);
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (do_idx) begin
      count <= '0;
    end else if (do_step) begin
      dir_up <= up;
      if (up) count <= at_top ? '0 : count + 1'b1;
      else    count <= at_zero ? ceil : count - 1'b1;
    end
  end

  assign ev_rst_up = (do_idx && dir_up) || (do_step && up && at_top);
  assign ev_rst_dn = (do_idx && !dir_up) || (do_step && !up && at_zero);
  assign ev_dir    = do_step && (up != dir_up);

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && up && count < ceil) |=> count == $past(count) + 1'b1);
  assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !up && at_zero) |=> count == $past(ceil));
  assert_idx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_idx |=> count == '0);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  output logic             irq
);
  localparam logic [CNT_W-1:0] WMASK = CNT_W'((1 << CB_EN) | (1 << CB_IDXRISE) |
                                              (1 << CB_SWAP) | (1 << CB_CEILMD) |
                                              (3 << CB_GATE));

  logic [CNT_W-1:0] ctrl_q, ceil_q, count;
  logic [ST_W-1:0]  stat_q, mask_q, set_v, clr_v;
  logic step, up, perr, idx_hit, ev_rst_up, ev_rst_dn, ev_dir;
  logic wr_ctrl, wr_ceil, wr_stat, wr_mask;

  assign wr_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign wr_ceil = wr_en && (wr_addr == AW'(ADDR_CEIL));
  assign wr_stat = wr_en && (wr_addr == AW'(ADDR_STAT));
  assign wr_mask = wr_en && (wr_addr == AW'(ADDR_MASK));

  qenc_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap     (ctrl_q[CB_SWAP]),
    .idx_rise (ctrl_q[CB_IDXRISE]),
    .gate     (ctrl_q[CB_GATE+1:CB_GATE]),
    .a_in     (phase_a),
    .b_in     (phase_b),
    .idx_in   (index_in),
    .step     (step),
    .up       (up),
    .perr     (perr),
    .idx_hit  (idx_hit)
  );

  qenc_position #(.CNT_W(CNT_W)) u_position (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_q[CB_EN]),
    .idx_mode  (!ctrl_q[CB_CEILMD]),
    .step      (step),
    .up        (up),
    .idx_hit   (idx_hit),
    .ceil      (ceil_q),
    .count     (count),
    .ev_rst_up (ev_rst_up),
    .ev_rst_dn (ev_rst_dn),
    .ev_dir    (ev_dir)
  );

  always_comb begin
    set_v            = '0;
    set_v[SB_RST_DN] = ev_rst_dn;
    set_v[SB_RST_UP] = ev_rst_up;
    set_v[SB_DIR]    = ev_dir;
    set_v[SB_PERR]   = ctrl_q[CB_EN] && perr;
    clr_v            = wr_stat ? wr_data[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ceil_q <= '1;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_ctrl) begin
        if (ctrl_q[CB_EN]) ctrl_q[CB_EN] <= wr_data[CB_EN];
        else               ctrl_q        <= wr_data & WMASK;
      end
      if (wr_ceil) ceil_q <= wr_data;
      if (wr_mask) mask_q <= wr_data[ST_W-1:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  assign irq = |(stat_q & ~mask_q);

  always_comb begin
    unique case (rd_addr)
      AW'(ADDR_CTRL): rd_data = ctrl_q;
      AW'(ADDR_CEIL): rd_data = ceil_q;
      AW'(ADDR_CNT):  rd_data = count;
      AW'(ADDR_STAT): rd_data = CNT_W'(stat_q);
      AW'(ADDR_MASK): rd_data = CNT_W'(mask_q);
      default:        rd_data = '0;
    endcase
  end

  assert_ctrl_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[CB_EN]) |=> ctrl_q[CNT_W-1:1] == $past(ctrl_q[CNT_W-1:1]));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (stat_q & $past(stat_q)) == $past(stat_q));
  assert_perr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_EN] && perr) |=> stat_q[SB_PERR]);
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wr_en, phase_a, phase_b, index_in, irq;
  logic [2:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  qenc_counter i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_ceil, m_cnt;
  logic [5:0]  m_st, m_mask;
  logic        m_dir, m_pa, m_pb, m_pi;
  logic        cur_a = 0, cur_b = 0, cur_i = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [2:0] addr, input logic [31:0] exp);
    rd_addr = addr;
    #1;
    chk(tag, "register read", rd_data, exp);
    rd_addr = 3'd2;
  endtask

  task automatic tick(input string tag, input logic a, input logic b, input logic i,
                      input logic we, input logic [2:0] wa, input logic [31:0] wd);
    logic ae, be, da, db, st, up, er, hit, en;
    logic [5:0] set, clr;
    phase_a = a; phase_b = b; index_in = i;
    wr_en = we; wr_addr = wa; wr_data = wd;
    cur_a = a; cur_b = b; cur_i = i;
    en  = m_ctrl[0];
    ae  = m_ctrl[5] ? b : a;
    be  = m_ctrl[5] ? a : b;
    da  = ae ^ m_pa;
    db  = be ^ m_pb;
    st  = da ^ db;
    er  = da & db;
    up  = ae ^ m_pb;
    hit = (m_ctrl[4] ? (i && !m_pi) : (!i && m_pi)) && ({ae, be} == m_ctrl[10:9]);
    set = '0;
    if (en) begin
      if (!m_ctrl[8] && hit) begin
        m_cnt = 0;
        if (m_dir) set[2] = 1; else set[1] = 1;
      end else if (st) begin
        if (up != m_dir) set[3] = 1;
        m_dir = up;
        if (up) begin
          if (m_cnt >= m_ceil) begin m_cnt = 0; set[2] = 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = m_ceil; set[1] = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (er) set[4] = 1;
    end
    clr = (we && wa == 3'd3) ? wd[5:0] : 6'd0;
    m_st = (m_st & ~clr) | set;
    if (we && wa == 3'd0) begin
      if (m_ctrl[0]) m_ctrl[0] = wd[0];
      else m_ctrl = wd & 32'h0000_0731;
    end
    if (we && wa == 3'd1) m_ceil = wd;
    if (we && wa == 3'd4) m_mask = wd[5:0];
    m_pa = ae; m_pb = be; m_pi = i;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    chk(tag, "count", rd_data, m_cnt);
    chk(tag, "irq", {31'd0, irq}, {31'd0, |(m_st & ~m_mask)});
  endtask

  task automatic mv(input string tag, input logic a, input logic b);
    tick(tag, a, b, cur_i, 1'b0, 3'd0, 32'd0);
  endtask
  task automatic ix(input string tag, input logic i);
    tick(tag, cur_a, cur_b, i, 1'b0, 3'd0, 32'd0);
  endtask
  task automatic wr(input string tag, input logic [2:0] addr, input logic [31:0] d);
    tick(tag, cur_a, cur_b, cur_i, 1'b1, addr, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 3'd2;
    phase_a = 0; phase_b = 0; index_in = 0;
    m_ctrl = 0; m_ceil = 32'hFFFF_FFFF; m_cnt = 0; m_st = 0; m_mask = 6'h3F;
    m_dir = 1; m_pa = 0; m_pb = 0; m_pi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 3'd0, 32'h0);
    rd("R1", 3'd1, 32'hFFFF_FFFF);
    rd("R1", 3'd2, 32'h0);
    rd("R1", 3'd3, 32'h0);
    rd("R1", 3'd4, 32'h3F);
    chk("R1", "irq", {31'd0, irq}, 32'd0);

    wr("R10", 3'd4, 32'h0);
    wr("R2", 3'd0, 32'h101);
    // R2 up order, two cycles
    for (int k = 0; k < 2; k++) begin
      mv("R2", 1, 0); mv("R2", 1, 1); mv("R2", 0, 1); mv("R2", 0, 0);
    end
    rd("R2", 3'd2, 32'd8);
    // R7 reverse order
    mv("R7", 0, 1); mv("R7", 1, 1); mv("R7", 1, 0); mv("R7", 0, 0);
    rd("R7", 3'd2, 32'd4);
    rd("R7", 3'd3, 32'h08);
    wr("R10", 3'd3, 32'h3F);
    rd("R10", 3'd3, 32'h0);
    // R3 double transition
    mv("R3", 1, 1);
    rd("R3", 3'd2, 32'd4);
    rd("R3", 3'd3, 32'h10);
    mv("R3", 0, 0);
    wr("R3", 3'd3, 32'h3F);
    // R8 disabled
    wr("R8", 3'd0, 32'h0);
    mv("R8", 1, 0); mv("R8", 1, 1); mv("R8", 1, 0); mv("R8", 0, 0);
    rd("R8", 3'd2, 32'd4);
    rd("R8", 3'd3, 32'h0);
    // R9 lock while enabled
    wr("R9", 3'd0, 32'h101);
    wr("R9", 3'd0, 32'h121);
    rd("R9", 3'd0, 32'h101);
    // R5 ceiling wrap both ways
    wr("R5", 3'd1, 32'd5);
    mv("R5", 1, 0);
    mv("R5", 1, 1);
    rd("R5", 3'd2, 32'd0);
    mv("R5", 1, 0);
    rd("R5", 3'd2, 32'd5);
    rd("R5", 3'd3, 32'h0E);
    wr("R5", 3'd3, 32'h3F);
    // R4 swap
    wr("R4", 3'd0, 32'h100);
    wr("R4", 3'd0, 32'h120);
    wr("R4", 3'd0, 32'h121);
    mv("R4", 1, 1);
    rd("R4", 3'd2, 32'd4);
    // R6 index, rising, gating 3
    wr("R6", 3'd0, 32'h0);
    wr("R6", 3'd0, 32'h611);
    wr("R6", 3'd3, 32'h3F);
    ix("R6", 1);
    rd("R6", 3'd2, 32'd0);
    rd("R6", 3'd3, 32'h02);
    ix("R6", 0);
    mv("R6", 1, 0);
    rd("R6", 3'd2, 32'd5);
    ix("R6", 1);
    rd("R6", 3'd2, 32'd5);
    ix("R6", 0);
    // R6 ceiling mode ignores index
    wr("R6", 3'd0, 32'h0);
    wr("R6", 3'd0, 32'h711);
    mv("R6", 0, 0); mv("R6", 0, 1); mv("R6", 1, 1);
    ix("R6", 1);
    rd("R6", 3'd2, 32'd2);
    // R6 falling edge select
    wr("R6", 3'd0, 32'h0);
    wr("R6", 3'd0, 32'h601);
    ix("R6", 0);
    rd("R6", 3'd2, 32'd0);
    // R10 masking
    wr("R10", 3'd4, 32'h3F);
    wr("R10", 3'd3, 32'h3F);
    mv("R10", 0, 1);
    rd("R10", 3'd3, 32'h08);
    chk("R10", "irq masked", {31'd0, irq}, 32'd0);
    wr("R10", 3'd4, 32'h37);
    chk("R10", "irq unmasked", {31'd0, irq}, 32'd1);
    wr("R10", 3'd3, 32'h08);
    chk("R10", "irq cleared", {31'd0, irq}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule